// File: doc/BRIEF.md
# Indirect register access bridge

This block connects a simple memory-mapped host bus to an internal register space that is wider than the host's 16-bit data path and that has more registers than the host port can address directly. The host sees seven direct registers: a status word, a revision word, an indirect address word and four data words. An internal register is named by a block type, an instance number and a parameter select. A single write to the indirect address word starts an internal transaction, which runs for a fixed number of clock cycles. While it runs, a busy flag is set.

An internal write commits all four staged data words, 64 bits in total, to the selected register at once. An internal read returns the one 16-bit word chosen by the read-back index in the address word, and places it in data word 0. A wide register is therefore read with one transaction per word. The internal register file is plain storage inside the block. The status word also holds two host-writable, active-low reset outputs.

Top module: `ireg_bridge`

## Requirements
- R1: Host byte offsets decode as follows: 0x10 is status, 0x20 is revision, 0x30 is the indirect address word, and 0x40, 0x50, 0x60 and 0x70 are data words 0 to 3. A read of any other offset returns 0. Host reads are combinational.
- R2: The revision word reads as follows: bit 15 is the inverse of the audio-present parameter, bits 14:12 are the board revision, bits 7:4 are the major revision, bits 3:0 are the minor revision, and every other bit is 0. Writes to it have no effect.
- R3: Status bit 3 drives `sys_rst_n` and status bit 4 drives `codec_rst_n`. Both are written by the host and both reset to 0. All other status bits ignore writes, and status bits 2:1 and 15:5 read 0.
- R4: A host write to offset 0x30 while the block is idle latches the address word and starts a transaction. Status bit 0 (busy) reads 1 for exactly 4 clock cycles, starting with the cycle after that write. A write to any other offset starts no transaction.
- R5: A write to offset 0x30 while busy is 1 is ignored. The address read-back keeps its value and no second transaction follows.
- R6: The address word has these fields: bits 15:12 are the block type, bits 11:8 are the instance, bit 7 is the direction (1 = read, 0 = write), bits 3:2 are the parameter and bits 1:0 are the read-back index. Bits 6:4 are ignored. A write transaction stores data words 0 to 3 as words 0 to 3 of the selected register.
- R7: A read transaction loads word N of the selected register into data word 0, where N is the read-back index. The value is readable in the cycle in which busy returns to 0. Data words 1 to 3 are not changed.
- R8: An internal address is decoded only when the block type is 1 to 3 and the instance is 1 to 2. An address that is not decoded reads as 0 and ignores writes.
- R9: A write transaction commits the data words as they stood when the address word was written. Data-word writes made while busy is 1 do not change the stored value.
- R10: After reset, all direct registers read 0 except revision, and all internal registers hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Host byte offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| sys_rst_n | output | 1 | Global reset output, from status bit 3 |
| codec_rst_n | output | 1 | Codec reset output, from status bit 4 |

## Verification
Host reads return data in the same cycle, so the bench samples them a short delay after a clock edge rather than at the edge. Busy is sampled after the edge of the launching write, which must read 1, and after each of the next three edges, which must also read 1. It is then sampled after the fourth edge, where it must read 0. The read result in data word 0 is checked only at that point. Reset outputs are checked just after the edge of the status write. A sweep writes every combination of type 0 to 15, instance 0 to 3 and parameter, then reads back every word. The expected value of each word is computed from the type, instance, parameter and word index, and is 0 where the address is not decoded.

// File: rtl/ireg_pkg.sv
package ireg_pkg;
  localparam int DATA_W = 16;
  localparam int WORDS  = 4;
  localparam int PARAMS = 4;

  localparam logic [7:0] OFS_STATUS = 8'h10;
  localparam logic [7:0] OFS_REV    = 8'h20;
  localparam logic [7:0] OFS_IADDR  = 8'h30;
  localparam logic [7:0] OFS_DATA0  = 8'h40;

  typedef struct packed {
    logic [3:0] blk;
    logic [3:0] inst;
    logic       rd;
    logic [2:0] spare;
    logic [1:0] param;
    logic [1:0] word;
  } iaddr_t;

  function automatic logic [7:0] data_ofs(input int k);
    return OFS_DATA0 + 8'(k * 16);
  endfunction

  function automatic logic addr_decoded(input logic [3:0] blk, input logic [3:0] inst,
                                        input int nblk, input int ninst);
    return (blk != 4'd0) && (int'(blk) <= nblk) && (inst != 4'd0) && (int'(inst) <= ninst);
  endfunction

  function automatic int reg_slot(input logic [3:0] blk, input logic [3:0] inst,
                                  input logic [1:0] param, input int ninst);
    return ((int'(blk) - 1) * ninst + int'(inst) - 1) * PARAMS + int'(param);
  endfunction

  function automatic logic [DATA_W-1:0] rev_word(input logic present, input logic [2:0] board,
                                                 input logic [3:0] major, input logic [3:0] minor);
    return {~present, board, 4'b0000, major, minor};
  endfunction
endpackage

// File: rtl/ireg_seq.sv
module ireg_seq #(
  parameter int XFER_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (XFER_CYCLES > 2) ? $clog2(XFER_CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign done = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (launch) begin
      busy  <= 1'b1;
      cnt_q <= CNT_W'(XFER_CYCLES - 1);
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ireg_store.sv
module ireg_store import ireg_pkg::*; #(
  parameter int NUM_BLK  = 3,
  parameter int NUM_INST = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit_wr,
  input  logic [3:0]                    blk,
  input  logic [3:0]                    inst,
  input  logic [1:0]                    param,
  input  logic [1:0]                    word,
  input  logic [WORDS-1:0][DATA_W-1:0]  wdata,
  output logic                          hit,
  output logic [DATA_W-1:0]             rword
);
  localparam int NREG  = NUM_BLK * NUM_INST * PARAMS;
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [WORDS-1:0][DATA_W-1:0] mem [NREG];
  logic [IDX_W-1:0]             slot;

  assign hit   = addr_decoded(blk, inst, NUM_BLK, NUM_INST);
  assign slot  = hit ? IDX_W'(reg_slot(blk, inst, param, NUM_INST)) : '0;
  assign rword = hit ? mem[slot][word] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) mem[r] <= '0;
    end else if (commit_wr && hit) begin
      mem[slot] <= wdata;
    end
  end
endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge import ireg_pkg::*; #(
  parameter int         NUM_BLK       = 3,
  parameter int         NUM_INST      = 2,
  parameter int         XFER_CYCLES   = 4,
  parameter logic       AUDIO_PRESENT = 1'b1,
  parameter logic [2:0] BOARD_REV     = 3'd2,
  parameter logic [3:0] CHIP_MAJOR    = 4'd1,
  parameter logic [3:0] CHIP_MINOR    = 4'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [7:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              sys_rst_n,
  output logic              codec_rst_n
);
  logic                         host_wr;
  logic                         launch;
  logic                         busy;
  logic                         txn_done;
  logic                         txn_hit;
  logic [DATA_W-1:0]            rword;
  iaddr_t                       iaddr_q;
  logic [WORDS-1:0][DATA_W-1:0] stage_q;
  logic [WORDS-1:0][DATA_W-1:0] snap_q;

  assign host_wr = host_sel && host_we;
  assign launch  = host_wr && (host_addr == OFS_IADDR) && !busy;

  ireg_seq #(.XFER_CYCLES(XFER_CYCLES)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .busy   (busy),
    .done   (txn_done)
  );

  ireg_store #(.NUM_BLK(NUM_BLK), .NUM_INST(NUM_INST)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_wr (txn_done && !iaddr_q.rd),
    .blk       (iaddr_q.blk),
    .inst      (iaddr_q.inst),
    .param     (iaddr_q.param),
    .word      (iaddr_q.word),
    .wdata     (snap_q),
    .hit       (txn_hit),
    .rword     (rword)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iaddr_q     <= '0;
      snap_q      <= '0;
      sys_rst_n   <= 1'b0;
      codec_rst_n <= 1'b0;
    end else begin
      if (launch) begin
        iaddr_q <= iaddr_t'(host_wdata);
        snap_q  <= stage_q;
      end
      if (host_wr && host_addr == OFS_STATUS) begin
        sys_rst_n   <= host_wdata[3];
        codec_rst_n <= host_wdata[4];
      end
    end
  end

  generate
    for (genvar k = 0; k < WORDS; k++) begin : g_data
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[k] <= '0;
        end else if (k == 0 && txn_done && iaddr_q.rd) begin
          stage_q[k] <= rword;
        end else if (host_wr && host_addr == data_ofs(k)) begin
          stage_q[k] <= host_wdata;
        end
      end
    end
  endgenerate

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      OFS_STATUS: host_rdata = {11'b0, codec_rst_n, sys_rst_n, 2'b00, busy};
      OFS_REV:    host_rdata = rev_word(AUDIO_PRESENT, BOARD_REV, CHIP_MAJOR, CHIP_MINOR);
      OFS_IADDR:  host_rdata = iaddr_q;
      default:    host_rdata = '0;
    endcase
    for (int k = 0; k < WORDS; k++) begin
      if (host_addr == data_ofs(k)) host_rdata = stage_q[k];
    end
  end
endmodule

// File: rtl/ireg_bridge_chk.sv
module ireg_bridge_chk import ireg_pkg::*; #(
  parameter int XFER_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel,
  input logic              host_we,
  input logic [7:0]        host_addr,
  input logic [1:0]        rst_bits,
  input logic              sys_rst_n,
  input logic              codec_rst_n,
  input logic              launch,
  input logic              busy,
  input logic              txn_done,
  input logic              txn_hit,
  input logic              txn_rd,
  input logic [DATA_W-1:0] iaddr_rb,
  input logic [DATA_W-1:0] data0
);
  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else        run_len <= busy ? run_len + 1 : 0;
  end

  assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == XFER_CYCLES);

  assert_launch_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (host_sel && host_we && host_addr == OFS_IADDR));

  assert_idle_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(txn_done));

  assert_ignore_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_sel && host_we && host_addr == OFS_IADDR) |=> $stable(iaddr_rb));

  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_done && txn_rd && !txn_hit) |=> data0 == '0);

  assert_rst_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_we && host_addr == OFS_STATUS) |=>
      (sys_rst_n == $past(rst_bits[0]) && codec_rst_n == $past(rst_bits[1])));
endmodule

bind ireg_bridge ireg_bridge_chk #(.XFER_CYCLES(XFER_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_sel    (host_sel),
  .host_we     (host_we),
  .host_addr   (host_addr),
  .rst_bits    (host_wdata[4:3]),
  .sys_rst_n   (sys_rst_n),
  .codec_rst_n (codec_rst_n),
  .launch      (launch),
  .busy        (busy),
  .txn_done    (txn_done),
  .txn_hit     (txn_hit),
  .txn_rd      (iaddr_q.rd),
  .iaddr_rb    (iaddr_q),
  .data0       (stage_q[0])
);

// File: tb/test_ireg_bridge.sv
module test_ireg_bridge;
  localparam int XFER = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_addr = 8'h00;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        sys_rst_n;
  logic        codec_rst_n;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ireg_bridge i_ireg_bridge (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_sel    (host_sel),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .sys_rst_n   (sys_rst_n),
    .codec_rst_n (codec_rst_n)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk);
    #1;
    host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [15:0] d);
    host_sel = 1'b1; host_we = 1'b0; host_addr = a;
    #1;
    d = host_rdata;
    host_sel = 1'b0;
  endtask

  task automatic run_txn(input logic [15:0] aw);
    hwr(8'h30, aw);
    repeat (XFER) @(posedge clk);
    #2;
  endtask

  function automatic logic [15:0] pat(input int t, input int i, input int p, input int w);
    return 16'((t << 12) | (i << 8) | (p << 6) | (w << 4) | ((t ^ 4'hA) & 15));
  endfunction

  function automatic bit decoded(input int t, input int i);
    return (t >= 1 && t <= 3 && i >= 1 && i <= 2);
  endfunction

  function automatic logic [15:0] aword(input int t, input int i, input bit rd,
                                        input int sp, input int p, input int w);
    return 16'((t << 12) | (i << 8) | (int'(rd) << 7) | (sp << 4) | (p << 2) | w);
  endfunction

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] a0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;

    // R10 reset state
    hrd(8'h10, v); chk("R10 status", v, 16'h0000);
    chk("R10 sys_rst_n", {15'b0, sys_rst_n}, 16'h0);
    chk("R10 codec_rst_n", {15'b0, codec_rst_n}, 16'h0);
    hrd(8'h30, v); chk("R10 iaddr", v, 16'h0000);
    for (int k = 0; k < 4; k++) begin
      hrd(8'(8'h40 + k * 16), v); chk("R10 data", v, 16'h0000);
    end
    run_txn(aword(1, 1, 1'b1, 0, 0, 0));
    hrd(8'h40, v); chk("R10 internal zero", v, 16'h0000);

    // R2 revision
    hrd(8'h20, v); chk("R2 revision", v, 16'((0 << 15) | (2 << 12) | (1 << 4) | 3));
    hwr(8'h20, 16'h5555);
    hrd(8'h20, v); chk("R2 revision write ignored", v, 16'h2013);

    // R1 unmapped offsets
    hrd(8'h00, v); chk("R1 unmapped 00", v, 16'h0);
    hrd(8'h38, v); chk("R1 unmapped 38", v, 16'h0);
    hrd(8'h80, v); chk("R1 unmapped 80", v, 16'h0);
    hrd(8'hF0, v); chk("R1 unmapped F0", v, 16'h0);

    // R3 status and reset outputs
    hwr(8'h10, 16'h0018);
    chk("R3 both released", {14'b0, codec_rst_n, sys_rst_n}, 16'h0003);
    hrd(8'h10, v); chk("R3 status 18", v, 16'h0018);
    hwr(8'h10, 16'hFFFF);
    hrd(8'h10, v); chk("R3 other bits ignored", v, 16'h0018);
    chk("R4 status write no launch", v & 16'h1, 16'h0);
    hwr(8'h10, 16'h0008);
    chk("R3 sys only", {14'b0, codec_rst_n, sys_rst_n}, 16'h0001);
    hwr(8'h10, 16'h0010);
    chk("R3 codec only", {14'b0, codec_rst_n, sys_rst_n}, 16'h0002);

    // R4 data writes do not launch
    hwr(8'h50, 16'h1234);
    hrd(8'h10, v); chk("R4 data write no launch", v & 16'h1, 16'h0);

    // R4 busy window
    hwr(8'h30, aword(2, 1, 1'b1, 0, 1, 0));
    #1;
    hrd(8'h10, v); chk("R4 busy cycle 1", v & 16'h1, 16'h1);
    for (int c = 2; c <= XFER; c++) begin
      @(posedge clk); #2;
      hrd(8'h10, v); chk("R4 busy held", v & 16'h1, 16'h1);
    end
    @(posedge clk); #2;
    hrd(8'h10, v); chk("R4 busy cleared", v & 16'h1, 16'h0);

    // R6/R8 sweep of writes: spare bits and index set nonzero
    for (int t = 0; t < 16; t++) begin
      for (int i = 0; i < 4; i++) begin
        for (int p = 0; p < 4; p++) begin
          for (int w = 0; w < 4; w++) hwr(8'(8'h40 + w * 16), pat(t, i, p, w));
          run_txn(aword(t, i, 1'b0, 5, p, 3));
        end
      end
    end

    // R7/R6/R8 read-back sweep
    for (int t = 0; t < 16; t++) begin
      for (int i = 0; i < 4; i++) begin
        for (int p = 0; p < 4; p++) begin
          for (int w = 0; w < 4; w++) begin
            run_txn(aword(t, i, 1'b1, 2, p, w));
            hrd(8'h40, v);
            if (decoded(t, i)) chk("R6 R7 readback word", v, pat(t, i, p, w));
            else               chk("R8 undecoded reads zero", v, 16'h0);
          end
        end
      end
    end
    hrd(8'h50, v); chk("R7 data1 kept", v, pat(15, 3, 3, 1));
    hrd(8'h60, v); chk("R7 data2 kept", v, pat(15, 3, 3, 2));
    hrd(8'h70, v); chk("R7 data3 kept", v, pat(15, 3, 3, 3));

    // R8 undecoded read overwrites nonzero data0
    hwr(8'h40, 16'hFFFF);
    run_txn(aword(4, 1, 1'b1, 0, 0, 0));
    hrd(8'h40, v); chk("R8 undecoded clears data0", v, 16'h0);

    // R9 snapshot and R5 ignored launch
    hwr(8'h40, 16'h1111); hwr(8'h50, 16'h2222);
    hwr(8'h60, 16'h3333); hwr(8'h70, 16'h4444);
    a0 = aword(1, 1, 1'b0, 0, 0, 0);
    hwr(8'h30, a0);
    hwr(8'h40, 16'hDEAD);
    hwr(8'h30, aword(2, 2, 1'b0, 0, 1, 0));
    hrd(8'h30, v); chk("R5 address kept while busy", v, a0);
    repeat (XFER) @(posedge clk);
    #2;
    hrd(8'h10, v); chk("R5 no second transaction", v & 16'h1, 16'h0);
    hrd(8'h30, v); chk("R5 address after done", v, a0);
    run_txn(aword(1, 1, 1'b1, 0, 0, 0));
    hrd(8'h40, v); chk("R9 snapshot word0", v, 16'h1111);
    run_txn(aword(1, 1, 1'b1, 0, 0, 3));
    hrd(8'h40, v); chk("R9 snapshot word3", v, 16'h4444);
    run_txn(aword(2, 2, 1'b1, 0, 1, 0));
    hrd(8'h40, v); chk("R5 ignored write left target", v, pat(2, 2, 1, 0));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule